// File: doc/BRIEF.md
# HI/LO Multiply-Divide-Accumulate Unit

This block holds the HI/LO register pair of an integer pipeline and runs every operation that reads or writes it. It covers signed and unsigned multiply into the 64-bit pair, and multiply-add and multiply-subtract on that 64-bit value. It also provides signed and unsigned divide, which leaves the quotient in LO and the remainder in HI. Moves between an operand and either half are included, as is a three-operand multiply that returns the low word of a signed product without touching the pair.

An operation is picked by a one-bit class and a six-bit function code. The class is 0 for the primary group and 1 for the secondary group. A one-cycle `start` strobe launches the operation. Multiplies, accumulates and moves finish at the first clock edge after the strobe. Division is a restoring iteration that takes one quotient bit per cycle, and `busy` is high while it runs. An issuer that sees `busy` high must stall and re-issue its operation later. The unit accepts no operation while `busy` is high.

Top module: `hilo_muldiv_unit`

## Requirements
- R1: After reset, HI, LO and `result` are all zero and `busy` is low.
- R2: In class 0, code 0x18 (signed) and code 0x19 (unsigned) form the 64-bit product of opA and opB. Bits 63:32 of the product go to HI and bits 31:0 go to LO, at the first edge after start.
- R3: In class 1, code 0x00 (signed) and code 0x01 (unsigned) add the 64-bit product to HI:LO. The sum wraps modulo 2^64, with the carry passing from LO into HI.
- R4: In class 1, code 0x04 (signed) and code 0x05 (unsigned) subtract the 64-bit product from HI:LO. The difference wraps modulo 2^64, with the borrow passing from LO into HI.
- R5: In class 1, code 0x02 puts the low 32 bits of the signed product of opA and opB on `result` one cycle after start. HI and LO keep their values.
- R6: In class 0, code 0x11 copies opA into HI and code 0x13 copies opA into LO. Code 0x10 places HI on `result` and code 0x12 places LO on `result`, in both cases one cycle after start.
- R7: In class 0, code 0x1A (signed) and code 0x1B (unsigned) divide opA by opB. `busy` is high for exactly 32 cycles starting the cycle after start. LO holds the quotient and HI holds the remainder once `busy` falls.
- R8: A signed divide truncates the quotient toward zero, and the remainder takes the sign of the dividend.
- R9: A divide by zero completes in the same number of cycles as any other divide, and leaves LO all ones and HI equal to the dividend.
- R10: A start while `busy` is high has no effect: it does not write HI or LO and does not change `result`.
- R11: A function code not listed above has no effect on HI, LO or `result`.
- R12: `result` holds its value until the next accepted read or three-operand multiply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle launch strobe |
| opClass | input | 1 | 0 = primary group, 1 = secondary group |
| opFunc | input | 6 | Function code within the group |
| opA | input | 32 | First operand (dividend, move source) |
| opB | input | 32 | Second operand (divisor) |
| busy | output | 1 | Divide in progress; new operations refused |
| result | output | 32 | Read-back value for moves from HI/LO and three-operand multiply |

## Verification
Multiplies, accumulates and moves into HI or LO take effect at the first rising edge after the strobe. A read or three-operand multiply shows on `result` after that same edge. A divide holds `busy` for 32 cycles, and its quotient and remainder are valid from the first cycle in which `busy` is low. The bench drives each strobe on a falling edge and samples at the next falling edge. After any divide it loops on `busy` before reading HI and LO back through the move codes. The busy-length check counts the falling edges at which `busy` is seen high.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

  // Class 0 function codes
  localparam logic [5:0] FN_RD_HI  = 6'h10;
  localparam logic [5:0] FN_WR_HI  = 6'h11;
  localparam logic [5:0] FN_RD_LO  = 6'h12;
  localparam logic [5:0] FN_WR_LO  = 6'h13;
  localparam logic [5:0] FN_MUL_S  = 6'h18;
  localparam logic [5:0] FN_MUL_U  = 6'h19;
  localparam logic [5:0] FN_DIV_S  = 6'h1A;
  localparam logic [5:0] FN_DIV_U  = 6'h1B;

  // Class 1 function codes
  localparam logic [5:0] FN_ACC_S  = 6'h00;
  localparam logic [5:0] FN_ACC_U  = 6'h01;
  localparam logic [5:0] FN_MUL3   = 6'h02;
  localparam logic [5:0] FN_DEC_S  = 6'h04;
  localparam logic [5:0] FN_DEC_U  = 6'h05;

  typedef struct packed {
    logic prodWr;    // write product or accumulation to HI:LO
    logic accAdd;    // add product to HI:LO
    logic accSub;    // subtract product from HI:LO
    logic signedOp;  // treat operands as signed
    logic hiWr;      // opA -> HI
    logic loWr;      // opA -> LO
    logic readHi;    // HI -> result
    logic readLo;    // LO -> result
    logic readMul;   // low product word -> result
    logic divStart;  // load divider
    logic divStep;   // one restoring iteration
    logic divDone;   // final iteration, write HI/LO
  } hilo_strobe_t;

endpackage

// File: rtl/hilo_ctrl.sv
module hilo_ctrl
  import hilo_pkg::*;
#(
  parameter int unsigned DIV_STEPS = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         opClass,
  input  logic [5:0]   opFunc,
  output logic         busy,
  output hilo_strobe_t strobe
);

  localparam int unsigned CNT_W = $clog2(DIV_STEPS + 1);

  logic [CNT_W-1:0] stepCnt;
  logic             busyQ;
  logic             accept;

  assign accept = start & ~busyQ;
  assign busy   = busyQ;

  always_comb begin
    strobe = '0;
    if (accept) begin
      if (!opClass) begin
        unique case (opFunc)
          FN_RD_HI: strobe.readHi = 1'b1;
          FN_RD_LO: strobe.readLo = 1'b1;
          FN_WR_HI: strobe.hiWr   = 1'b1;
          FN_WR_LO: strobe.loWr   = 1'b1;
          FN_MUL_S: begin strobe.prodWr = 1'b1; strobe.signedOp = 1'b1; end
          FN_MUL_U: strobe.prodWr = 1'b1;
          FN_DIV_S: begin strobe.divStart = 1'b1; strobe.signedOp = 1'b1; end
          FN_DIV_U: strobe.divStart = 1'b1;
          default: ;
        endcase
      end else begin
        unique case (opFunc)
          FN_ACC_S: begin strobe.prodWr = 1'b1; strobe.accAdd = 1'b1; strobe.signedOp = 1'b1; end
          FN_ACC_U: begin strobe.prodWr = 1'b1; strobe.accAdd = 1'b1; end
          FN_DEC_S: begin strobe.prodWr = 1'b1; strobe.accSub = 1'b1; strobe.signedOp = 1'b1; end
          FN_DEC_U: begin strobe.prodWr = 1'b1; strobe.accSub = 1'b1; end
          FN_MUL3:  begin strobe.readMul = 1'b1; strobe.signedOp = 1'b1; end
          default: ;
        endcase
      end
    end
    strobe.divStep = busyQ;
    strobe.divDone = busyQ && (stepCnt == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      stepCnt <= '0;
    end else if (strobe.divStart) begin
      busyQ   <= 1'b1;
      stepCnt <= CNT_W'(DIV_STEPS);
    end else if (busyQ) begin
      stepCnt <= stepCnt - CNT_W'(1);
      if (stepCnt == CNT_W'(1)) busyQ <= 1'b0;
    end
  end

endmodule

// File: rtl/hilo_datapath.sv
module hilo_datapath
  import hilo_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  hilo_strobe_t      strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result
);

  localparam int unsigned EXT_W  = DATA_W + 1;
  localparam int unsigned PROD_W = 2 * DATA_W;
  localparam int unsigned MSB    = DATA_W - 1;

  logic [DATA_W-1:0] hiQ, loQ, resQ;

  // Multiplier, with sign extension selected per operation
  logic signed [EXT_W-1:0]   aExt, bExt;
  logic signed [2*EXT_W-1:0] prodFull;
  logic [PROD_W-1:0]         prod, hiLo, accum;

  assign aExt     = {strobe.signedOp & opA[MSB], opA};
  assign bExt     = {strobe.signedOp & opB[MSB], opB};
  assign prodFull = aExt * bExt;
  assign prod     = prodFull[PROD_W-1:0];
  assign hiLo     = {hiQ, loQ};
  assign accum    = strobe.accSub ? (hiLo - prod) : (hiLo + prod);

  // Restoring divider on magnitudes
  logic [DATA_W-1:0] quotQ, remQ, divisorQ;
  logic              negQuotQ, negRemQ, zeroDivQ;
  logic [EXT_W-1:0]  shifted, trial;
  logic              fits;
  logic [DATA_W-1:0] quotNext, remNext, loFinal, hiFinal;
  logic [DATA_W-1:0] magA, magB;
  logic              negA, negB;

  assign negA     = strobe.signedOp & opA[MSB];
  assign negB     = strobe.signedOp & opB[MSB];
  assign magA     = negA ? (~opA + DATA_W'(1)) : opA;
  assign magB     = negB ? (~opB + DATA_W'(1)) : opB;

  assign shifted  = {remQ, quotQ[MSB]};
  assign trial    = shifted - {1'b0, divisorQ};
  assign fits     = ~trial[EXT_W-1];
  assign remNext  = fits ? trial[DATA_W-1:0] : shifted[DATA_W-1:0];
  assign quotNext = {quotQ[DATA_W-2:0], fits};
  assign loFinal  = zeroDivQ ? '1 : (negQuotQ ? (~quotNext + DATA_W'(1)) : quotNext);
  assign hiFinal  = negRemQ ? (~remNext + DATA_W'(1)) : remNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quotQ    <= '0;
      remQ     <= '0;
      divisorQ <= '0;
      negQuotQ <= 1'b0;
      negRemQ  <= 1'b0;
      zeroDivQ <= 1'b0;
    end else if (strobe.divStart) begin
      quotQ    <= magA;
      remQ     <= '0;
      divisorQ <= magB;
      negQuotQ <= negA ^ negB;
      negRemQ  <= negA;
      zeroDivQ <= (opB == '0);
    end else if (strobe.divStep) begin
      quotQ <= quotNext;
      remQ  <= remNext;
    end
  end

  // HI/LO pair
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiQ <= '0;
      loQ <= '0;
    end else if (strobe.divDone) begin
      hiQ <= hiFinal;
      loQ <= loFinal;
    end else if (strobe.prodWr) begin
      {hiQ, loQ} <= (strobe.accAdd | strobe.accSub) ? accum : prod;
    end else begin
      if (strobe.hiWr) hiQ <= opA;
      if (strobe.loWr) loQ <= opA;
    end
  end

  // Read-back register
  always_ff @(posedge clk) begin
    if (!rstN)               resQ <= '0;
    else if (strobe.readHi)  resQ <= hiQ;
    else if (strobe.readLo)  resQ <= loQ;
    else if (strobe.readMul) resQ <= prod[DATA_W-1:0];
  end

  assign result = resQ;

endmodule

// File: rtl/hilo_muldiv_unit.sv
module hilo_muldiv_unit
  import hilo_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              opClass,
  input  logic [5:0]        opFunc,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              busy,
  output logic [DATA_W-1:0] result
);

  localparam int unsigned DIV_STEPS = DATA_W;

  hilo_strobe_t strobe;

  hilo_ctrl #(.DIV_STEPS(DIV_STEPS)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .opClass (opClass),
    .opFunc  (opFunc),
    .busy    (busy),
    .strobe  (strobe)
  );

  hilo_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );

endmodule

// File: rtl/hilo_checker.sv
module hilo_checker #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned DIV_STEPS = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              opClass,
  input logic [5:0]        opFunc,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              busy,
  input logic [DATA_W-1:0] result
);

  logic [15:0]       busyCnt;
  logic [DATA_W-1:0] mulLow;
  logic              mul3Go, divGo;

  assign mulLow = opA * opB;
  assign mul3Go = start && !busy && opClass && (opFunc == 6'h02);
  assign divGo  = start && !busy && !opClass && (opFunc[5:1] == 5'h0D);

  always_ff @(posedge clk) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 16'd1;
    else           busyCnt <= '0;
  end

  // R7: busy rises only after an accepted divide strobe
  p_busy_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(divGo));

  // R7: busy stays high for exactly the divide step count
  p_busy_len_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyCnt == 16'(DIV_STEPS)));

  // R5: three-operand multiply returns the low product word
  p_mul_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    mul3Go |=> (result == $past(mulLow)));

  // R12: result changes only after an accepted strobe
  p_result_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> $past(start && !busy));

endmodule

bind hilo_muldiv_unit hilo_checker #(.DATA_W(DATA_W), .DIV_STEPS(DATA_W)) i_hilo_checker (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .opClass (opClass),
  .opFunc  (opFunc),
  .opA     (opA),
  .opB     (opB),
  .busy    (busy),
  .result  (result)
);

// File: tb/test_hilo_muldiv_unit.sv
module test_hilo_muldiv_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        opClass = 1'b0;
  logic [5:0]  opFunc = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        busy;
  logic [31:0] result;

  int nChecks = 0;
  int nFail   = 0;

  always #10 clk = ~clk;  // 50 MHz

  hilo_muldiv_unit i_hilo_muldiv_unit (
    .clk(clk), .rstN(rstN), .start(start), .opClass(opClass), .opFunc(opFunc),
    .opA(opA), .opB(opB), .busy(busy), .result(result)
  );

  typedef struct packed {
    logic        cls;
    logic [5:0]  fn;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] eHi;
    logic [31:0] eLo;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'h11, 32'h12345678, 32'h0,        32'h12345678, 32'h00000000}, // R6 write HI
    '{1'b0, 6'h13, 32'hCAFEF00D, 32'h0,        32'h12345678, 32'hCAFEF00D}, // R6 write LO
    '{1'b0, 6'h19, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h00000001}, // R2 unsigned
    '{1'b0, 6'h18, 32'hFFFFFFFF, 32'h00000002, 32'hFFFFFFFF, 32'hFFFFFFFE}, // R2 signed
    '{1'b1, 6'h01, 32'h00000001, 32'h00000002, 32'h00000000, 32'h00000000}, // R3 wrap
    '{1'b1, 6'h00, 32'hFFFFFFFF, 32'h00000003, 32'hFFFFFFFF, 32'hFFFFFFFD}, // R3 signed
    '{1'b1, 6'h04, 32'hFFFFFFFF, 32'h00000003, 32'h00000000, 32'h00000000}, // R4 signed
    '{1'b1, 6'h05, 32'h00000002, 32'h80000000, 32'hFFFFFFFF, 32'h00000000}, // R4 borrow
    '{1'b1, 6'h01, 32'h0000FFFF, 32'h00010001, 32'hFFFFFFFF, 32'hFFFFFFFF}, // R3 unsigned
    '{1'b0, 6'h1B, 32'd100,      32'd7,        32'd2,        32'd14},       // R7 unsigned
    '{1'b0, 6'h1A, 32'hFFFFFFF9, 32'd2,        32'hFFFFFFFF, 32'hFFFFFFFD}, // R8 -7/2
    '{1'b0, 6'h1A, 32'd7,        32'hFFFFFFFE, 32'd1,        32'hFFFFFFFD}, // R8 7/-2
    '{1'b0, 6'h1A, 32'hFFFFFFF9, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'd3},        // R8 -7/-2
    '{1'b0, 6'h1B, 32'hFFFFFFF9, 32'd2,        32'd1,        32'h7FFFFFFC}, // R7 large
    '{1'b0, 6'h1B, 32'h00001234, 32'd0,        32'h00001234, 32'hFFFFFFFF}, // R9 unsigned
    '{1'b0, 6'h1A, 32'hFFFFFFFB, 32'd0,        32'hFFFFFFFB, 32'hFFFFFFFF}, // R9 signed
    '{1'b0, 6'h1A, 32'h80000000, 32'hFFFFFFFF, 32'h00000000, 32'h80000000}, // R8 overflow
    '{1'b0, 6'h14, 32'h55555555, 32'h1,        32'h00000000, 32'h80000000}, // R11 class 0
    '{1'b1, 6'h03, 32'h55555555, 32'h1,        32'h00000000, 32'h80000000}  // R11 class 1
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic cls, input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    start = 1'b1; opClass = cls; opFunc = fn; opA = a; opB = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitIdle;
    while (busy) @(negedge clk);
  endtask

  task automatic readPair(output logic [31:0] hiV, output logic [31:0] loV);
    issue(1'b0, 6'h10, '0, '0);
    hiV = result;
    issue(1'b0, 6'h12, '0, '0);
    loV = result;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] hiV, loV, held;
    int cnt;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", {31'b0, busy}, 32'h0);
    check("R1 result", result, 32'h0);
    readPair(hiV, loV);
    check("R1 HI", hiV, 32'h0);
    check("R1 LO", loV, 32'h0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].cls, VECS[i].fn, VECS[i].a, VECS[i].b);
      waitIdle();
      readPair(hiV, loV);
      check($sformatf("vector %0d HI", i), hiV, VECS[i].eHi);
      check($sformatf("vector %0d LO", i), loV, VECS[i].eLo);
    end

    // R5 three-operand multiply leaves HI/LO alone
    issue(1'b0, 6'h11, 32'hAAAA5555, '0);
    issue(1'b0, 6'h13, 32'h0F0F0F0F, '0);
    issue(1'b1, 6'h02, 32'hFFFFFFFD, 32'd5);
    check("R5 mul -3*5", result, 32'hFFFFFFF1);
    issue(1'b1, 6'h02, 32'h00010000, 32'h00010001);
    check("R5 mul low word", result, 32'h00010000);
    readPair(hiV, loV);
    check("R5 HI kept", hiV, 32'hAAAA5555);
    check("R5 LO kept", loV, 32'h0F0F0F0F);

    // R7 busy length
    issue(1'b0, 6'h1B, 32'd100, 32'd7);
    check("R7 busy after start", {31'b0, busy}, 32'h1);
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    check("R7 busy cycles", 32'(cnt), 32'd32);

    // R9 divide by zero takes the same time
    issue(1'b0, 6'h1A, 32'h00000042, 32'd0);
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    check("R9 busy cycles", 32'(cnt), 32'd32);

    // R10 strobes while busy are refused
    issue(1'b0, 6'h12, '0, '0);
    held = result;
    issue(1'b0, 6'h1B, 32'd1000, 32'd10);
    issue(1'b0, 6'h11, 32'hDEADBEEF, '0);
    issue(1'b0, 6'h10, '0, '0);
    check("R10 result during busy", result, held);
    waitIdle();
    readPair(hiV, loV);
    check("R10 HI not overwritten", hiV, 32'd0);
    check("R10 LO quotient", loV, 32'd100);

    // R12 result holds while idle
    held = result;
    repeat (5) @(negedge clk);
    check("R12 result held", result, held);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule